// File: doc/BRIEF.md
# I2C Slave Bit Engine with High-Speed Mode Entry

This block is the bit-level front end of an I2C slave. It watches the SCL and SDA lines through a synchroniser, recognises bus conditions (START, repeated START, STOP) and shifts bytes in and out MSB first. It drives SDA only through an active-high pull-low enable, so the pad stays open-drain. Received write bytes are handed to a byte layer with a one-cycle valid strobe. For reads, the byte layer keeps a byte ready on its transmit input, and the engine takes it whenever a new read byte begins.

When the bus is in Fast-mode, the engine treats a byte of the form 0000_1xxx sent right after a START as a high-speed master code. It never acknowledges that byte and switches an internal mode flag to Hs-mode, which it reports as a status output. The flag survives any number of repeated STARTs, so the master can chain several high-speed transfers. It drops back to Fast-mode only when a STOP is seen. In either mode, a matching 7-bit address (a parameter) is acknowledged. A transfer to any other address is ignored until the next bus condition.

Top module: `i2c_hs_slave`

## Requirements
- R1: After reset, sda_oe is 0, hs_mode is 0 and no event, valid or request strobe is active.
- R2: start_evt pulses once for every START or repeated START (SDA falling while SCL is high). stop_evt pulses once for every STOP (SDA rising while SCL is high).
- R3: In Fast-mode, a byte whose upper five bits are 00001, received first after a START, is never acknowledged: sda_oe stays 0 through its ACK slot.
- R4: After a master code's ACK slot, hs_mode becomes 1 and stays 1 across repeated STARTs.
- R5: hs_mode returns to 0 only on a STOP condition.
- R6: A first byte whose upper seven bits equal SLAVE_ADDR is acknowledged: sda_oe is 1 during its ACK slot. Bit 0 of that byte selects the direction, 0 for write and 1 for read.
- R7: After a non-matching address, the engine acknowledges nothing and raises no rx_valid until the next START or STOP.
- R8: In a write transfer, each data byte is assembled MSB first, presented on rx_data with a one-cycle rx_valid pulse, and acknowledged.
- R9: In a read transfer, tx_data is sampled at the SCL falling edge that ends the address ACK slot or a master ACK slot. tx_req pulses in that cycle, and the byte is driven MSB first, with sda_oe = 1 for a 0 bit.
- R10: When the master answers a read byte with SDA high (not-acknowledge), the engine releases SDA and makes no further tx_req until the next START.
- R11: Apart from bus conditions, sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| start_evt | output | 1 | One-cycle pulse on START or repeated START |
| stop_evt | output | 1 | One-cycle pulse on STOP |
| rx_data | output | 8 | Last received write byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data holds a new byte |
| tx_data | input | 8 | Next byte to send in a read transfer |
| tx_req | output | 1 | Pulse when tx_data has been taken |
| hs_mode | output | 1 | 1 while the bus is in Hs-mode |

## Verification
The bench builds the engine with SLAVE_ADDR = 7'h51 and three synchroniser stages. The odd address makes address bit 0 and the direction bit differ in value. The extra stage lengthens the delay between a pad change and the engine's reaction, which tests whether SDA still changes only inside the SCL low phase. With the address 0x51, nearby mismatching addresses such as 0x52 and 0x50 can be tested. A byte that is a master code in Fast-mode can be sent and then, within the same Hs session, followed by a chained read and write.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W);

    // line indices inside the synchroniser bundle
    localparam int LN_SCL   = 0;
    localparam int LN_SDA   = 1;
    localparam int LN_COUNT = 2;

    // upper bits that mark a high-speed master code
    localparam int MC_BITS = 5;
    localparam logic [MC_BITS-1:0] MC_PREFIX = 5'b00001;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_MC_NACK,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_IGNORE
    } xfer_state_e;

    typedef enum logic {
        MODE_FAST = 1'b0,
        MODE_HS   = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic scl;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } line_view_t;

    typedef struct packed {
        logic start;
        logic stop;
    } bus_cond_t;

    function automatic logic is_master_code(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1 -: MC_BITS] == MC_PREFIX;
    endfunction

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] a);
        return b[BYTE_W-1:1] == a;
    endfunction

endpackage

// File: rtl/hs_line_sync.sv
module hs_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= '1;
                prev <= 1'b1;
            end else begin
                pipe[0] <= raw[g];
                for (int k = 1; k < STAGES; k++) begin
                    pipe[k] <= pipe[k-1];
                end
                prev <= pipe[STAGES-1];
            end
        end

        assign lvl[g]  = pipe[STAGES-1];
        assign rise[g] = pipe[STAGES-1] & ~prev;
        assign fall[g] = ~pipe[STAGES-1] & prev;
    end

endmodule

// File: rtl/hs_cond_detect.sv
module hs_cond_detect
    import i2c_hs_pkg::*;
(
    input  logic       scl_lvl,
    input  logic       scl_rise,
    input  logic       sda_rise,
    input  logic       sda_fall,
    output bus_cond_t  cond
);

    logic scl_steady_high;

    assign scl_steady_high = scl_lvl & ~scl_rise;
    assign cond.start      = sda_fall & scl_steady_high;
    assign cond.stop       = sda_rise & scl_steady_high;

endmodule

// File: rtl/hs_xfer_fsm.sv
module hs_xfer_fsm
    import i2c_hs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  line_view_t        line,
    input  bus_cond_t         cond,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              tx_req,
    output logic              hs_mode
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    xfer_state_e       state;
    bus_mode_e         mode;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_done;
    logic              dir_read;
    logic              master_ack;

    always_ff @(posedge clk) begin
        rx_valid <= 1'b0;
        tx_req   <= 1'b0;
        if (rst) begin
            state      <= ST_IDLE;
            mode       <= MODE_FAST;
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_done  <= 1'b0;
            dir_read   <= 1'b0;
            master_ack <= 1'b0;
            sda_oe     <= 1'b0;
            rx_data    <= '0;
        end else if (cond.stop) begin
            state     <= ST_IDLE;
            mode      <= MODE_FAST;
            sda_oe    <= 1'b0;
            byte_done <= 1'b0;
        end else if (cond.start) begin
            state     <= ST_ADDR;
            bit_cnt   <= '0;
            sda_oe    <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (line.scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], line.sda};
                        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
                    end
                    if (line.scl_fall && byte_done) begin
                        byte_done <= 1'b0;
                        if (mode == MODE_FAST && is_master_code(shreg)) begin
                            state <= ST_MC_NACK;
                        end else if (addr_hit(shreg, SLAVE_ADDR)) begin
                            dir_read <= shreg[0];
                            sda_oe   <= 1'b1;
                            state    <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_MC_NACK: begin
                    if (line.scl_rise) begin
                        mode  <= MODE_HS;
                        state <= ST_IDLE;
                    end
                end
                ST_ADDR_ACK: begin
                    if (line.scl_fall) begin
                        bit_cnt <= '0;
                        if (dir_read) begin
                            shreg  <= tx_data;
                            sda_oe <= ~tx_data[BYTE_W-1];
                            tx_req <= 1'b1;
                            state  <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (line.scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], line.sda};
                        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) begin
                            rx_data   <= {shreg[BYTE_W-2:0], line.sda};
                            rx_valid  <= 1'b1;
                            byte_done <= 1'b1;
                        end
                    end
                    if (line.scl_fall && byte_done) begin
                        byte_done <= 1'b0;
                        sda_oe    <= 1'b1;
                        state     <= ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (line.scl_fall) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (line.scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            sda_oe    <= 1'b0;
                            byte_done <= 1'b0;
                            state     <= ST_RD_ACK;
                        end else begin
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe  <= ~shreg[BYTE_W-2];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (line.scl_rise) begin
                        master_ack <= ~line.sda;
                        byte_done  <= 1'b1;
                    end
                    if (line.scl_fall && byte_done) begin
                        byte_done <= 1'b0;
                        bit_cnt   <= '0;
                        if (master_ack) begin
                            shreg  <= tx_data;
                            sda_oe <= ~tx_data[BYTE_W-1];
                            tx_req <= 1'b1;
                            state  <= ST_RD;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign hs_mode = (mode == MODE_HS);

    // R3
    mc_unacked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_mode) |-> !$past(sda_oe));

    // R5
    hs_exit_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_mode) |-> $past(cond.stop));

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!cond.start && !cond.stop && !$stable(sda_oe)) |-> !line.scl);

    // R10
    ignore_released_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    // R8
    rx_tx_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !tx_req);

endmodule

// File: rtl/i2c_hs_slave.sv
module i2c_hs_slave
    import i2c_hs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h3C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              start_evt,
    output logic              stop_evt,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_req,
    output logic              hs_mode
);

    logic [LN_COUNT-1:0] lvl, rise, fall, raw;
    line_view_t          line;
    bus_cond_t           cond;

    always_comb begin
        raw         = '0;
        raw[LN_SCL] = scl_i;
        raw[LN_SDA] = sda_i;
    end

    hs_line_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (LN_COUNT)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    hs_cond_detect u_cond (
        .scl_lvl  (lvl[LN_SCL]),
        .scl_rise (rise[LN_SCL]),
        .sda_rise (rise[LN_SDA]),
        .sda_fall (fall[LN_SDA]),
        .cond     (cond)
    );

    assign line.scl      = lvl[LN_SCL];
    assign line.scl_rise = rise[LN_SCL];
    assign line.scl_fall = fall[LN_SCL];
    assign line.sda      = lvl[LN_SDA];

    hs_xfer_fsm #(
        .SLAVE_ADDR (SLAVE_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .line     (line),
        .cond     (cond),
        .tx_data  (tx_data),
        .sda_oe   (sda_oe),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .tx_req   (tx_req),
        .hs_mode  (hs_mode)
    );

    assign start_evt = cond.start;
    assign stop_evt  = cond.stop;

    // R2
    cond_excl_chk: assert property (@(posedge clk) disable iff (rst)
        start_evt |-> !stop_evt);

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> !start_evt);

endmodule

// File: tb/i2c_hs_slave_test.sv
module i2c_hs_slave_test;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe, start_evt, stop_evt, rx_valid, tx_req, hs_mode;
    logic [7:0] rx_data, tx_data;

    int checks = 0;
    int failures = 0;
    int start_cnt = 0, stop_cnt = 0, rx_cnt = 0, tx_cnt = 0, oe_viol = 0;
    logic [7:0] last_rx = 8'h00;
    logic       prev_scl = 1'b1, prev_oe = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    function automatic logic [7:0] tx_pat(input int k);
        return 8'hC3 ^ 8'(k * 37);
    endfunction

    assign tx_data = tx_pat(tx_cnt);

    i2c_hs_slave #(
        .SLAVE_ADDR  (7'h51),
        .SYNC_STAGES (3)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .tx_data   (tx_data),
        .tx_req    (tx_req),
        .hs_mode   (hs_mode)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (start_evt) start_cnt <= start_cnt + 1;
            if (stop_evt)  stop_cnt  <= stop_cnt + 1;
            if (tx_req)    tx_cnt    <= tx_cnt + 1;
            if (rx_valid) begin
                rx_cnt  <= rx_cnt + 1;
                last_rx <= rx_data;
            end
        end
    end

    // R11 monitor: sda_oe must not move while SCL stays high
    always @(negedge clk) begin
        if (!rst && scl_m && prev_scl && sda_oe !== prev_oe) oe_viol <= oe_viol + 1;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); wq();
        scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        scl_m = 1'b0; wq();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; wq();
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
        end
        scl_m = 1'b0; wq();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = sda_oe;
        wq();
        scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; wq();
            sda_m = 1'b1; wq();
            scl_m = 1'b1; wq();
            b[i] = sda_line;
            wq();
        end
        scl_m = 1'b0; wq();
        sda_m = ~give_ack; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    // {address byte, data byte, expect acknowledge}
    localparam logic [16:0] WR_TAB [0:4] = '{
        {8'hA2, 8'h3C, 1'b1},
        {8'hA2, 8'hFF, 1'b1},
        {8'hA2, 8'h00, 1'b1},
        {8'hA4, 8'h5A, 1'b0},
        {8'hA0, 8'h81, 1'b0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        int         rx0, tx0, st0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        chk(hs_mode == 1'b0, "R1 hs_mode", hs_mode, 0);
        chk(start_cnt == 0 && rx_cnt == 0 && tx_cnt == 0, "R1 strobes", start_cnt + rx_cnt + tx_cnt, 0);

        // table of Fast-mode write transfers: R6 R7 R8
        for (int v = 0; v < 5; v++) begin
            rx0 = rx_cnt;
            bus_start();
            send_byte(WR_TAB[v][16:9], ack);
            chk(ack == WR_TAB[v][0], "R6/R7 address ack", ack, WR_TAB[v][0]);
            send_byte(WR_TAB[v][8:1], ack);
            chk(ack == WR_TAB[v][0], "R8/R7 data ack", ack, WR_TAB[v][0]);
            chk(rx_cnt - rx0 == int'(WR_TAB[v][0]), "R8/R7 rx_valid count", rx_cnt - rx0, WR_TAB[v][0]);
            if (WR_TAB[v][0]) chk(last_rx == WR_TAB[v][8:1], "R8 rx_data", last_rx, WR_TAB[v][8:1]);
            bus_stop();
        end
        chk(start_cnt == 5, "R2 start count", start_cnt, 5);
        chk(stop_cnt == 5, "R2 stop count", stop_cnt, 5);

        // R7: several bytes after a mismatch stay unacknowledged
        rx0 = rx_cnt;
        bus_start();
        send_byte(8'hA4, ack);
        send_byte(8'hA2, ack);
        chk(ack == 1'b0, "R7 later byte ack", ack, 0);
        send_byte(8'h11, ack);
        chk(ack == 1'b0, "R7 later byte ack", ack, 0);
        chk(rx_cnt == rx0, "R7 rx_valid", rx_cnt - rx0, 0);
        bus_stop();

        // Fast-mode read, one byte, master NACK
        tx0 = tx_cnt;
        bus_start();
        send_byte(8'hA3, ack);
        chk(ack == 1'b1, "R6 read address ack", ack, 1);
        read_byte(1'b0, rb);
        chk(rb == tx_pat(tx0), "R9 fast read byte", rb, tx_pat(tx0));
        chk(hs_mode == 1'b0, "R4 no hs without master code", hs_mode, 0);
        bus_stop();

        // master code then chained Hs transfers
        st0 = start_cnt;
        bus_start();
        send_byte(8'h0B, ack);
        chk(ack == 1'b0, "R3 master code not acked", ack, 0);
        chk(hs_mode == 1'b1, "R4 hs after master code", hs_mode, 1);
        bus_rstart();
        chk(hs_mode == 1'b1, "R4 hs kept over Sr", hs_mode, 1);
        tx0 = tx_cnt;
        send_byte(8'hA3, ack);
        chk(ack == 1'b1, "R6 hs read address ack", ack, 1);
        for (int k = 0; k < 3; k++) begin
            read_byte(k < 2, rb);
            chk(rb == tx_pat(tx0 + k), "R9 hs read byte", rb, tx_pat(tx0 + k));
        end
        chk(sda_oe == 1'b0, "R10 released after NACK", sda_oe, 0);
        chk(tx_cnt - tx0 == 3, "R10 tx_req count", tx_cnt - tx0, 3);
        // extra clocks after the NACK must not draw another byte
        send_byte(8'hFF, ack);
        chk(tx_cnt - tx0 == 3 && ack == 1'b0, "R10 idle after NACK", tx_cnt - tx0, 3);
        bus_rstart();
        chk(hs_mode == 1'b1, "R5 hs kept over second Sr", hs_mode, 1);
        rx0 = rx_cnt;
        send_byte(8'hA2, ack);
        chk(ack == 1'b1, "R6 hs write address ack", ack, 1);
        send_byte(8'h0C, ack);
        chk(ack == 1'b1 && rx_cnt - rx0 == 1, "R8 hs write ack", ack, 1);
        chk(last_rx == 8'h0C, "R8 hs rx_data not master code", last_rx, 8'h0C);
        chk(start_cnt - st0 == 3, "R2 repeated START count", start_cnt - st0, 3);
        bus_stop();
        chk(hs_mode == 1'b0, "R5 hs cleared by STOP", hs_mode, 0);

        chk(oe_viol == 0, "R11 sda_oe moved with SCL high", oe_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule